// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block keeps track of up to 256 interrupt vectors for one processor. It holds three bit arrays, each indexed by vector number: a pending array, an in-service array and a trigger-mode array. Each array is stored as eight 32-bit words. A request port marks a vector pending and records whether its source is level or edge triggered. A lower vector number ranks ahead of a higher one. The block raises a registered interrupt line whenever the best pending vector ranks ahead of everything currently in service.

The processor takes an interrupt through the acknowledge port. In the same cycle it receives the winning vector number, and on the next edge that vector moves from pending to in-service. An end-of-interrupt strobe retires the best in-service vector. A small register port reads any word of the three arrays. The same port holds a task-priority register and a spurious/enable register. Bit 8 of the spurious/enable register is the software enable, and it gates all delivery.

Top module: `vec_irq_tracker`

## Requirements
- R1: When `req_valid` is high at a clock edge, the pending bit of `req_vector` is set. Its trigger-mode bit becomes `req_level` (1 = level, 0 = edge).
- R2: The winning pending vector is the lowest-numbered set bit. The search takes the first non-zero 32-bit word from word 0 upward, then the lowest set bit in that word, so the result is word*32 + bit.
- R3: `irq_out` is registered. One cycle after any change it is 1 exactly when three things hold: the software enable is 1, a vector is pending, and either nothing is in service or the winning pending vector is numbered below the lowest in-service vector.
- R4: This requirement applies when `ack_valid` is high, the software enable is 1 and a vector is pending. In that cycle `ack_none` is 0 and `ack_vector` carries the winner. At the next edge the winner's pending bit clears and its in-service bit sets.
- R5: This requirement applies when `ack_valid` is high and either the software enable is 0 or nothing is pending. Then `ack_none` is 1, and neither the pending array nor the in-service array changes because of the acknowledge.
- R6: At an edge where `eoi` is high, the lowest-numbered in-service bit clears. With nothing in service, `eoi` changes nothing. If the same cycle also acknowledges, the vector being acknowledged is set in service.
- R7: A request and an accepted acknowledge for the same vector in the same cycle leave that vector's pending bit set, and the vector still enters service.
- R8: A task-priority write stores `reg_wdata[3:0]` shifted left by 4. It reads back as an 8-bit value with zeros above.
- R9: The spurious/enable register resets to 0x0FF, so software enable is off after reset. A write stores `reg_wdata[8:0]`, and bit 8 is the software enable.
- R10: `reg_addr[4:3]` selects the region: 0 pending, 1 in-service, 2 trigger-mode, 3 control. `reg_addr[2:0]` selects the array word. In the control region, word 0 is task priority and word 1 is spurious/enable. Every other address reads 0. Writes to the array regions are ignored.
- R11: After reset all three arrays are clear, task priority is 0 and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 8 | Vector being requested |
| req_level | input | 1 | 1 = level triggered, 0 = edge |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_vector | output | 8 | Winning pending vector (combinational) |
| ack_none | output | 1 | No vector can be delivered (combinational) |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_out | output | 1 | Interrupt line to the processor |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
A behavioural model compares the block on every clock for each of the following patterns. Vectors are placed in different words and at different bit positions within a word, which shows whether the search order runs word-first and lowest-bit-first. Nested service puts a higher-ranked request on top of an active handler, and then a lower-ranked one, which shows whether the interrupt line compares pending against in-service. End-of-interrupt is issued with several vectors in service and with none, which shows that retirement takes the top vector only. Same-cycle collisions (request plus acknowledge of one vector, acknowledge plus end-of-interrupt) and a long randomly mixed sequence cover orderings that the directed cases miss.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    RGN_PEND = 2'd0,
    RGN_SVC  = 2'd1,
    RGN_TRIG = 2'd2,
    RGN_CTRL = 2'd3
  } region_e;

  localparam int CTRL_TPR_WORD  = 0;
  localparam int CTRL_SPUR_WORD = 1;
  localparam int SPUR_W         = 9;
  localparam int SPUR_EN_BIT    = 8;
  localparam logic [SPUR_W-1:0] SPUR_RESET = 9'h0FF;

  // task priority: low nibble of the write moved to the upper nibble
  function automatic logic [7:0] tpr_pack(input logic [31:0] wd);
    return {wd[3:0], 4'h0};
  endfunction

  function automatic logic [SPUR_W-1:0] spur_pack(input logic [31:0] wd);
    return wd[SPUR_W-1:0];
  endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NBITS  = 256,
  parameter int WORD_W = 32,
  localparam int NWORDS = NBITS / WORD_W,
  localparam int IDX_W  = $clog2(NBITS),
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int WSEL_W = $clog2(NWORDS)
) (
  input  logic [NBITS-1:0] vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  logic [NWORDS-1:0]       word_any;
  logic [NWORDS*BIT_W-1:0] word_lsb;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] slice;
    logic [BIT_W-1:0]  lsb;
    assign slice = vec[w*WORD_W +: WORD_W];
    always_comb begin
      lsb = '0;
      for (int b = WORD_W - 1; b >= 0; b--)
        if (slice[b]) lsb = BIT_W'(b);
    end
    assign word_any[w] = |slice;
    assign word_lsb[w*BIT_W +: BIT_W] = lsb;
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = NWORDS - 1; w >= 0; w--)
      if (word_any[w]) begin
        found = 1'b1;
        idx   = {WSEL_W'(w), word_lsb[w*BIT_W +: BIT_W]};
      end
  end

  // R2: the reported bit is set and nothing below it is set
  logic [NBITS-1:0] below_mask;
  assign below_mask = (NBITS'(1) << idx) - NBITS'(1);
  always_comb begin
    if (found) begin
      enc_hit_set_chk: assert (vec[idx]);
      enc_lowest_chk:  assert ((vec & below_mask) == '0);
    end
  end

endmodule

// File: rtl/irq_regport.sv
module irq_regport
  import irq_pkg::*;
#(
  parameter int NBITS  = 256,
  parameter int WORD_W = 32,
  localparam int NWORDS = NBITS / WORD_W,
  localparam int WSEL_W = $clog2(NWORDS),
  localparam int ADDR_W = WSEL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [NBITS-1:0]  pend,
  input  logic [NBITS-1:0]  svc,
  input  logic [NBITS-1:0]  trig,
  output logic [31:0]       rdata,
  output logic              sw_en
);

  logic [7:0]        tpr_q;
  logic [SPUR_W-1:0] spur_q;
  region_e           rgn;
  logic [WSEL_W-1:0] word;
  logic              wr_tpr, wr_spur;

  assign rgn     = region_e'(addr[ADDR_W-1 -: 2]);
  assign word    = addr[WSEL_W-1:0];
  assign wr_tpr  = wr && rgn == RGN_CTRL && int'(word) == CTRL_TPR_WORD;
  assign wr_spur = wr && rgn == RGN_CTRL && int'(word) == CTRL_SPUR_WORD;
  assign sw_en   = spur_q[SPUR_EN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q  <= '0;
      spur_q <= SPUR_RESET;
    end else begin
      if (wr_tpr)  tpr_q  <= tpr_pack(wdata);
      if (wr_spur) spur_q <= spur_pack(wdata);
    end
  end

  always_comb begin
    rdata = '0;
    unique case (rgn)
      RGN_PEND: rdata = 32'(pend[int'(word)*WORD_W +: WORD_W]);
      RGN_SVC:  rdata = 32'(svc[int'(word)*WORD_W +: WORD_W]);
      RGN_TRIG: rdata = 32'(trig[int'(word)*WORD_W +: WORD_W]);
      RGN_CTRL: begin
        if (int'(word) == CTRL_TPR_WORD)  rdata = 32'(tpr_q);
        if (int'(word) == CTRL_SPUR_WORD) rdata = 32'(spur_q);
      end
      default: rdata = '0;
    endcase
  end

  // R9
  spur_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_spur |=> spur_q == $past(wdata[SPUR_W-1:0]));
  // R8
  tpr_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tpr |=> tpr_q[3:0] == 4'h0);

endmodule

// File: rtl/vec_irq_tracker.sv
module vec_irq_tracker
  import irq_pkg::*;
#(
  parameter int NVEC   = 256,
  parameter int WORD_W = 32,
  localparam int NWORDS = NVEC / WORD_W,
  localparam int IDX_W  = $clog2(NVEC),
  localparam int WSEL_W = $clog2(NWORDS),
  localparam int ADDR_W = WSEL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_vector,
  input  logic              req_level,
  input  logic              ack_valid,
  output logic [IDX_W-1:0]  ack_vector,
  output logic              ack_none,
  input  logic              eoi,
  output logic              irq_out,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  logic [NVEC-1:0]  pend_q, svc_q, trig_q;
  logic [NVEC-1:0]  pend_d, svc_d, trig_d;
  logic             pend_any, svc_any, sw_en;
  logic [IDX_W-1:0] pend_top, svc_top;
  logic             ack_fire, eoi_fire, irq_cond, irq_q;

  irq_prio_enc #(.NBITS(NVEC), .WORD_W(WORD_W)) u_pend_enc (
    .vec(pend_q), .found(pend_any), .idx(pend_top));

  irq_prio_enc #(.NBITS(NVEC), .WORD_W(WORD_W)) u_svc_enc (
    .vec(svc_q), .found(svc_any), .idx(svc_top));

  irq_regport #(.NBITS(NVEC), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .pend(pend_q), .svc(svc_q), .trig(trig_q),
    .rdata(reg_rdata), .sw_en(sw_en));

  // named events for the assertions
  assign ack_fire = ack_valid && sw_en && pend_any;
  assign eoi_fire = eoi && svc_any;
  assign irq_cond = sw_en && pend_any && (!svc_any || pend_top < svc_top);

  assign ack_vector = pend_top;
  assign ack_none   = !(sw_en && pend_any);
  assign irq_out    = irq_q;

  always_comb begin
    pend_d = pend_q;
    svc_d  = svc_q;
    trig_d = trig_q;
    if (ack_fire) pend_d[pend_top] = 1'b0;
    if (req_valid) begin
      pend_d[req_vector] = 1'b1;
      trig_d[req_vector] = req_level;
    end
    if (eoi_fire) svc_d[svc_top] = 1'b0;
    if (ack_fire) svc_d[pend_top] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      svc_q  <= '0;
      trig_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      svc_q  <= svc_d;
      trig_q <= trig_d;
      irq_q  <= irq_cond;
    end
  end

  // R1
  req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pend_q[$past(req_vector)] && trig_q[$past(req_vector)] == $past(req_level));
  // R3
  irq_idle_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && pend_any && !svc_any) |=> irq_out);
  // R3
  irq_none_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_any || !sw_en) |=> !irq_out);
  // R4
  ack_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> svc_q[$past(pend_top)]);
  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !(req_valid && req_vector == pend_top)) |=> !pend_q[$past(pend_top)]);
  // R5
  ack_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_fire && !eoi) |=> $stable(svc_q));
  // R6
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !(ack_fire && pend_top == svc_top)) |=> !svc_q[$past(svc_top)]);
  // R7
  req_ack_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && req_valid && req_vector == pend_top) |=> pend_q[$past(req_vector)]);

endmodule

// File: tb/tb_vec_irq_tracker.sv
module tb_vec_irq_tracker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_level, ack_valid, eoi, reg_wr;
  logic [7:0]  req_vector;
  logic [7:0]  ack_vector;
  logic        ack_none, irq_out;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_irq_tracker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_level(req_level), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .ack_none(ack_none), .eoi(eoi), .irq_out(irq_out), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // behavioural reference
  bit m_pend[256];
  bit m_svc[256];
  bit m_trig[256];
  int m_tpr;
  int m_spur;
  bit m_irq;

  function automatic int lowest(input bit which_svc);
    for (int i = 0; i < 256; i++)
      if (which_svc ? m_svc[i] : m_pend[i]) return i;
    return -1;
  endfunction

  function automatic bit m_en();
    return m_spur[8];
  endfunction

  function automatic logic [31:0] m_read(input int a);
    logic [31:0] r = 0;
    int rg = a / 8;
    int w  = a % 8;
    for (int b = 0; b < 32; b++) begin
      if (rg == 0) r[b] = m_pend[w*32+b];
      if (rg == 1) r[b] = m_svc[w*32+b];
      if (rg == 2) r[b] = m_trig[w*32+b];
    end
    if (rg == 3 && w == 0) r = m_tpr;
    if (rg == 3 && w == 1) r = m_spur;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: inputs applied at negedge, comb outputs checked, model advanced
  task automatic step(input bit rq, input int rv, input bit rl, input bit ak,
                      input bit eo, input bit wr, input int addr, input logic [31:0] wd);
    int ptop, stop, rg, w;
    bit en, fire, irq_nx;
    logic [31:0] exp;
    req_valid = rq; req_vector = 8'(rv); req_level = rl;
    ack_valid = ak; eoi = eo; reg_wr = wr; reg_addr = 5'(addr); reg_wdata = wd;
    #1;
    ptop = lowest(0);
    stop = lowest(1);
    en   = m_en();
    exp  = m_read(addr);
    // R10 register read map
    check(reg_rdata === exp, "R10 read", reg_rdata, exp);
    if (ak) begin
      // R5 refusal / R4 acceptance
      check(ack_none === !(en && ptop >= 0), "R5 ack_none", 32'(ack_none), 32'(!(en && ptop >= 0)));
      // R2 winner number
      if (en && ptop >= 0)
        check(ack_vector === 8'(ptop), "R2 R4 ack_vector", 32'(ack_vector), 32'(ptop));
    end
    @(posedge clk);
    fire   = ak && en && ptop >= 0;
    irq_nx = en && ptop >= 0 && (stop < 0 || ptop < stop);
    if (fire) m_pend[ptop] = 0;
    if (rq) begin m_pend[rv] = 1; m_trig[rv] = rl; end   // R1, R7
    if (eo && stop >= 0) m_svc[stop] = 0;                // R6
    if (fire) m_svc[ptop] = 1;                           // R4
    rg = addr / 8; w = addr % 8;
    if (wr && rg == 3 && w == 0) m_tpr = {24'd0, wd[3:0], 4'd0};   // R8
    if (wr && rg == 3 && w == 1) m_spur = {23'd0, wd[8:0]};        // R9
    m_irq = irq_nx;
    @(negedge clk);
    // R3 interrupt line
    check(irq_out === m_irq, "R3 irq_out", 32'(irq_out), 32'(m_irq));
  endtask

  task automatic idle(input int addr);
    step(0, 0, 0, 0, 0, 0, addr, 0);
  endtask

  task automatic sweep();
    for (int a = 0; a < 32; a++) idle(a);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    req_valid = 0; req_vector = 0; req_level = 0; ack_valid = 0;
    eoi = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    for (int i = 0; i < 256; i++) begin m_pend[i] = 0; m_svc[i] = 0; m_trig[i] = 0; end
    m_tpr = 0; m_spur = 'h0FF; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R11 reset state (and R9 reset value) over the whole map
    check(irq_out === 1'b0, "R11 irq reset", 32'(irq_out), 0);
    sweep();

    // enable off: request is recorded but not delivered
    step(1, 40, 1, 0, 0, 0, 1, 0);          // R1 level request, word 1
    idle(1); idle(17);
    step(0, 0, 0, 1, 0, 0, 0, 0);           // R5 refused while disabled
    idle(8);

    // enable delivery; upper bits dropped
    step(0, 0, 0, 0, 0, 1, 25, 32'hFFFF_F1FF);  // R9
    idle(25); idle(25);
    step(0, 0, 0, 1, 0, 0, 9, 0);           // R4 ack of 40
    idle(9); idle(1);

    // higher-ranked request nests; lower-ranked one waits
    step(1, 100, 0, 0, 0, 0, 3, 0);         // R1 edge request
    step(1, 5, 1, 0, 0, 0, 0, 0);
    idle(16);
    step(0, 0, 0, 1, 0, 0, 8, 0);           // R2: 5 beats 100
    idle(8);                                // R3: 100 ranks below 40/5
    step(0, 0, 0, 0, 1, 0, 8, 0);           // R6 retires 5
    idle(9);
    step(0, 0, 0, 0, 1, 0, 9, 0);           // R6 retires 40, 100 now wins
    idle(11);
    step(0, 0, 0, 1, 0, 0, 11, 0);
    step(0, 0, 0, 0, 1, 0, 11, 0);
    step(0, 0, 0, 0, 1, 0, 11, 0);          // R6 nothing in service: no effect
    idle(11);

    // lowest bit inside a word vs first word
    step(1, 255, 0, 0, 0, 0, 7, 0);
    step(1, 33, 0, 0, 0, 0, 1, 0);
    step(1, 63, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0, 0, 1, 0);           // R2 expect 33
    // R7: request + ack of same vector
    step(1, 63, 1, 1, 0, 0, 1, 0);
    idle(9); idle(1);
    // ack and eoi together
    step(0, 0, 0, 1, 1, 0, 15, 0);          // R6 R4
    idle(15);

    // task priority
    step(0, 0, 0, 0, 0, 1, 24, 32'h0000_00AB);  // R8
    idle(24);
    // array writes ignored, unmapped read zero
    step(0, 0, 0, 0, 0, 1, 2, 32'hFFFF_FFFF);   // R10
    idle(2); idle(30); idle(26);

    // disabling drops the line
    step(0, 0, 0, 0, 0, 1, 25, 32'h0000_00FF);  // R9 enable off
    step(0, 0, 0, 1, 0, 0, 25, 0);              // R5
    idle(0);
    step(0, 0, 0, 0, 0, 1, 25, 32'h0000_0100);

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      int a = $urandom_range(0, 31);
      bit w = ($urandom_range(0, 19) == 0);
      logic [31:0] d = (a == 25) ? (32'h100 | 32'($urandom_range(0, 255))) : $urandom;
      if ($urandom_range(0, 40) == 0) d = 32'h0FF;
      step($urandom_range(0, 2) == 0, $urandom_range(0, 255), $urandom_range(0, 1),
           $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, w, a, d);
    end
    sweep();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule